// File: doc/BRIEF.md
# Halt and Wake-up Power Controller

This block manages low-power halt for a small microcontroller core. When the core executes its halt instruction, the controller records the power-down status and leaves the running state. It then drives clock-enable outputs for the main system clock, the display clock and the watchdog clock. What those enables do is set by a small halt-control register, by a static display option and by which oscillator feeds the system clock. While halted, the block watches for a wake event. A wake event is a watchdog overflow, a new interrupt request, or a falling edge on any port pin whose wake enable is set.

Once woken, the controller holds the core stalled for a fixed settling window. In the last cycle of that window it presents a one-hot resume action: continue at the next instruction, take an interrupt, or perform a warm reset (program counter and stack pointer only). The synchronous reset input acts as power-up and external reset and initialises everything. The watchdog-clear instruction clears the power-down flag.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset, the flags `pdf` and `tof` are 0, `ctl_rdata` is 0x00, `halted`, `cpu_stall`, `wdt_restart` and `resume_act` are 0, and all three clock enables are 1.
- R2: A `halt_req` pulse while running enters halt on the next edge. It sets `pdf` to 1 and clears `tof`, and `halted` and `cpu_stall` go to 1.
- R3: Writing the halt-control register stores bit 7 (oscillator keep) and bit 0 (display keep). Bits 6 to 1 always read as 0.
- R4: While halted, `main_clk_en` equals bit 7 of the register. When `sysclk_is_lf` is 1 the register is ignored and `main_clk_en` is 0. Outside halt, `main_clk_en` is 1.
- R5: While halted, `lcd_clk_en` is 1 when bits 7 and 0 are both 1 and `sysclk_is_lf` is 0. Otherwise it equals `lcd_opt`. Outside halt it is 1.
- R6: While halted, `wdt_clk_en` equals `wdt_src_ok`. `wdt_restart` is a one-cycle pulse in the first halted cycle, and it occurs only when `wdt_src_ok` is 1.
- R7: A falling edge on a port pin whose `port_wake_en` bit is 1 wakes the block, with action next-instruction. Rising edges, and edges on disabled pins, leave it halted.
- R8: An interrupt request bit that was 0 at halt entry and rises during halt wakes the block. The action is interrupt when that request's `irq_en` bit is 1 and `stack_full` is 0. Otherwise the action is next-instruction.
- R9: A request bit that was already 1 at halt entry cannot wake the block. It is re-armed once it has dropped to 0 during halt.
- R10: A watchdog overflow during halt wakes the block with action warm-reset and sets `tof`. A watchdog overflow wins over a simultaneous interrupt or pin wake.
- R11: After a wake, `cpu_stall` stays 1 with `halted` 0 for exactly SETTLE_CYCLES (1024) cycles. `resume_act` is one-hot only in the last of those cycles, and is 0 otherwise. Its encoding is bit 0 = next instruction, bit 1 = interrupt, bit 2 = warm reset.
- R12: A `wdt_clr` pulse while running, with no `halt_req`, clears `pdf`. A wake does not clear `pdf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high reset (power-up / external reset) |
| halt_req | input | 1 | Core executed halt (one-cycle pulse) |
| wdt_clr | input | 1 | Core executed watchdog clear (one-cycle pulse) |
| ctl_wr | input | 1 | Halt-control register write strobe |
| ctl_wdata | input | 8 | Halt-control register write data |
| ctl_rdata | output | 8 | Halt-control register read data |
| sysclk_is_lf | input | 1 | Low-frequency oscillator selected as system clock |
| lcd_opt | input | 1 | Static display-clock option used during halt |
| wdt_src_ok | input | 1 | Watchdog clocked from its own or the real-time oscillator |
| port_in | input | N_PINS | Raw port pin levels |
| port_wake_en | input | N_PINS | Per-pin wake enable |
| irq_req | input | N_IRQ | Interrupt request flags |
| irq_en | input | N_IRQ | Interrupt enables |
| stack_full | input | 1 | Core return stack is full |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| halted | output | 1 | Controller is in halt |
| cpu_stall | output | 1 | Core must not execute |
| main_clk_en | output | 1 | Main system clock enable |
| lcd_clk_en | output | 1 | Display clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| wdt_restart | output | 1 | Clear-and-restart pulse to the watchdog |
| pdf | output | 1 | Power-down flag |
| tof | output | 1 | Time-out flag |
| resume_act | output | 3 | One-hot resume action |

## Verification
The halt-and-wake path is exercised with a set of vectors. They combine the two control bits, the low-frequency clock select, the display option and the watchdog source with each of the three wake kinds. The clock-enable values taken while halted show whether the register is honoured or overridden. The resume action shows how interrupt enable and stack fullness steer an interrupt wake, and that pin and watchdog wakes have fixed outcomes. Directed cases then check the following:
- An interrupt pending at halt entry, a rising pin edge and a falling edge on a disabled pin all leave the block halted.
- Dropping and re-raising the pending request re-arms it.
- A simultaneous watchdog overflow takes priority.
- The settling window is counted exactly on every wake.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    localparam int CTL_W       = 8;
    localparam int CTL_OSC_BIT = 7;
    localparam int CTL_LCD_BIT = 0;
    localparam int ACT_W       = 3;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SETTLE = 2'd2
    } hwc_state_e;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE = 3'b000,
        ACT_NEXT = 3'b001,
        ACT_IRQ  = 3'b010,
        ACT_WARM = 3'b100
    } hwc_act_e;

    typedef struct packed {
        logic osc_keep;
        logic lcd_keep;
    } hwc_ctl_t;

    function automatic hwc_ctl_t ctl_from_bus(input logic [CTL_W-1:0] d);
        hwc_ctl_t c;
        c.osc_keep = d[CTL_OSC_BIT];
        c.lcd_keep = d[CTL_LCD_BIT];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_to_bus(input hwc_ctl_t c);
        logic [CTL_W-1:0] d;
        d = '0;
        d[CTL_OSC_BIT] = c.osc_keep;
        d[CTL_LCD_BIT] = c.lcd_keep;
        return d;
    endfunction

    // Watchdog wins, then interrupt, then port pin.
    function automatic hwc_act_e pick_action(input logic wdt_hit,
                                             input logic irq_hit,
                                             input logic irq_taken);
        if (wdt_hit)
            return ACT_WARM;
        else if (irq_hit && irq_taken)
            return ACT_IRQ;
        else
            return ACT_NEXT;
    endfunction

endpackage

// File: rtl/hwc_ctl_reg.sv
module hwc_ctl_reg
    import hwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output hwc_ctl_t         ctl,
    output logic [CTL_W-1:0] rdata
);
    hwc_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr)
            ctl_q <= ctl_from_bus(wdata);
    end

    assign ctl   = ctl_q;
    assign rdata = ctl_to_bus(ctl_q);
endmodule

// File: rtl/hwc_pin_edge.sv
module hwc_pin_edge #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pins,
    input  logic [N_PINS-1:0] en,
    output logic [N_PINS-1:0] fall
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic s1, s2, prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b1;
                s2   <= 1'b1;
                prev <= 1'b1;
            end else begin
                s1   <= pins[i];
                s2   <= s1;
                prev <= s2;
            end
        end
        assign fall[i] = en[i] & prev & ~s2;
    end
endmodule

// File: rtl/hwc_wake_qual.sv
module hwc_wake_qual
    import hwc_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             stack_full,
    input  logic             wdt_ovf,
    input  logic             pin_any,
    output logic             wake,
    output hwc_act_e         act
);
    logic [N_IRQ-1:0] pend_q;
    logic [N_IRQ-1:0] fresh;
    logic             irq_hit;
    logic             irq_taken;

    // Requests present at halt entry are masked until they drop.
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else if (capture)
            pend_q <= irq_req;
        else
            pend_q <= pend_q & irq_req;
    end

    assign fresh     = irq_req & ~pend_q;
    assign irq_hit   = |fresh;
    assign irq_taken = (|(fresh & irq_en)) & ~stack_full;
    assign wake      = wdt_ovf | irq_hit | pin_any;
    assign act       = pick_action(wdt_ovf, irq_hit, irq_taken);
endmodule

// File: rtl/hwc_settle_cnt.sv
module hwc_settle_cnt #(
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != LAST_V)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == LAST_V);
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwc_pkg::*;
#(
    parameter int N_PINS        = 8,
    parameter int N_IRQ         = 4,
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_req,
    input  logic              wdt_clr,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              sysclk_is_lf,
    input  logic              lcd_opt,
    input  logic              wdt_src_ok,
    input  logic [N_PINS-1:0] port_in,
    input  logic [N_PINS-1:0] port_wake_en,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic              stack_full,
    input  logic              wdt_ovf,
    output logic              halted,
    output logic              cpu_stall,
    output logic              main_clk_en,
    output logic              lcd_clk_en,
    output logic              wdt_clk_en,
    output logic              wdt_restart,
    output logic              pdf,
    output logic              tof,
    output logic [2:0]        resume_act
);
    hwc_state_e        st_q;
    hwc_act_e          act_q;
    hwc_ctl_t          ctl;
    hwc_act_e          wake_act;
    logic [N_PINS-1:0] pin_fall;
    logic              wake;
    logic              capture;
    logic              settle_last;
    logic              pdf_q, tof_q, restart_q;
    logic              in_halt, in_settle;
    logic              keep_osc, keep_lcd;

    hwc_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .rdata (ctl_rdata)
    );

    hwc_pin_edge #(.N_PINS(N_PINS)) u_pins (
        .clk  (clk),
        .rst  (rst),
        .pins (port_in),
        .en   (port_wake_en),
        .fall (pin_fall)
    );

    assign in_halt   = (st_q == ST_HALT);
    assign in_settle = (st_q == ST_SETTLE);
    assign capture   = (st_q == ST_RUN) && halt_req;

    hwc_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .stack_full (stack_full),
        .wdt_ovf    (wdt_ovf),
        .pin_any    (|pin_fall),
        .wake       (wake),
        .act        (wake_act)
    );

    hwc_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .run  (in_settle),
        .last (settle_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_RUN;
            act_q     <= ACT_NONE;
            pdf_q     <= 1'b0;
            tof_q     <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            unique case (st_q)
                ST_RUN: begin
                    if (halt_req) begin
                        st_q      <= ST_HALT;
                        pdf_q     <= 1'b1;
                        tof_q     <= 1'b0;
                        restart_q <= wdt_src_ok;
                    end else begin
                        if (wdt_clr) pdf_q <= 1'b0;
                        if (wdt_ovf) tof_q <= 1'b1;
                    end
                end
                ST_HALT: begin
                    if (wake) begin
                        st_q  <= ST_SETTLE;
                        act_q <= wake_act;
                    end
                    if (wdt_ovf) tof_q <= 1'b1;
                end
                ST_SETTLE: begin
                    if (settle_last) begin
                        st_q  <= ST_RUN;
                        act_q <= ACT_NONE;
                    end
                    if (wdt_ovf) tof_q <= 1'b1;
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    // The register only counts when the main oscillator is the system clock.
    assign keep_osc = ctl.osc_keep & ~sysclk_is_lf;
    assign keep_lcd = keep_osc & ctl.lcd_keep;

    assign halted      = in_halt;
    assign cpu_stall   = in_halt | in_settle;
    assign main_clk_en = in_halt ? keep_osc : 1'b1;
    assign lcd_clk_en  = in_halt ? (keep_lcd | lcd_opt) : 1'b1;
    assign wdt_clk_en  = in_halt ? wdt_src_ok : 1'b1;
    assign wdt_restart = restart_q;
    assign pdf         = pdf_q;
    assign tof         = tof_q;
    assign resume_act  = settle_last ? act_q : ACT_NONE;
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
    parameter int SETTLE_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst,
    input logic       halt_req,
    input logic       wdt_clr,
    input logic       wdt_ovf,
    input logic       sysclk_is_lf,
    input logic [7:0] ctl_rdata,
    input logic       halted,
    input logic       cpu_stall,
    input logic       main_clk_en,
    input logic       wdt_restart,
    input logic       pdf,
    input logic       tof,
    input logic [2:0] resume_act
);
    int unsigned settle_n;

    always_ff @(posedge clk) begin
        if (rst || !(cpu_stall && !halted))
            settle_n <= 0;
        else
            settle_n <= settle_n + 1;
    end

    a_r2_halt_flags: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> (pdf && !tof && cpu_stall));

    a_r3_unused_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[6:1] == 6'd0);

    a_r4_lf_gates_main: assert property (@(posedge clk) disable iff (rst)
        (halted && sysclk_is_lf) |-> !main_clk_en);

    a_r4_run_main_on: assert property (@(posedge clk) disable iff (rst)
        !cpu_stall |-> main_clk_en);

    a_r6_restart_pulse: assert property (@(posedge clk) disable iff (rst)
        wdt_restart |-> (halted && $rose(halted)));

    a_r10_wdt_wakes: assert property (@(posedge clk) disable iff (rst)
        (halted && wdt_ovf) |=> (tof && !halted && cpu_stall));

    a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resume_act));

    a_r11_window_len: assert property (@(posedge clk) disable iff (rst)
        (resume_act != 3'b000) |-> (cpu_stall && !halted && settle_n == SETTLE_CYCLES - 1));

    a_r11_release: assert property (@(posedge clk) disable iff (rst)
        (resume_act != 3'b000) |=> !cpu_stall);

    a_r12_clear_pdf: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stall && wdt_clr && !halt_req) |=> !pdf);
endmodule

bind halt_wake_ctrl hwc_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .halt_req     (halt_req),
    .wdt_clr      (wdt_clr),
    .wdt_ovf      (wdt_ovf),
    .sysclk_is_lf (sysclk_is_lf),
    .ctl_rdata    (ctl_rdata),
    .halted       (halted),
    .cpu_stall    (cpu_stall),
    .main_clk_en  (main_clk_en),
    .wdt_restart  (wdt_restart),
    .pdf          (pdf),
    .tof          (tof),
    .resume_act   (resume_act)
);

// File: tb/sim_halt_wake_ctrl.sv
module sim_halt_wake_ctrl;
    localparam int NP = 8;
    localparam int NI = 4;
    localparam int SC = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          halt_req = 0, wdt_clr = 0, ctl_wr = 0;
    logic [7:0]    ctl_wdata = '0;
    logic [7:0]    ctl_rdata;
    logic          sysclk_is_lf = 0, lcd_opt = 0, wdt_src_ok = 1;
    logic [NP-1:0] port_in = '1, port_wake_en = 8'h01;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic          stack_full = 0, wdt_ovf = 0;
    logic          halted, cpu_stall, main_clk_en, lcd_clk_en, wdt_clk_en;
    logic          wdt_restart, pdf, tof;
    logic [2:0]    resume_act;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    halt_wake_ctrl #(.N_PINS(NP), .N_IRQ(NI), .SETTLE_CYCLES(SC)) u0 (
        .clk(clk), .rst(rst), .halt_req(halt_req), .wdt_clr(wdt_clr),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sysclk_is_lf(sysclk_is_lf), .lcd_opt(lcd_opt), .wdt_src_ok(wdt_src_ok),
        .port_in(port_in), .port_wake_en(port_wake_en),
        .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
        .wdt_ovf(wdt_ovf), .halted(halted), .cpu_stall(cpu_stall),
        .main_clk_en(main_clk_en), .lcd_clk_en(lcd_clk_en),
        .wdt_clk_en(wdt_clk_en), .wdt_restart(wdt_restart),
        .pdf(pdf), .tof(tof), .resume_act(resume_act)
    );

    // kind: 0 = port pin fall, 1 = interrupt request, 2 = watchdog overflow
    typedef struct packed {
        logic [7:0] ctl;
        logic       lf;
        logic       lopt;
        logic       wsrc;
        logic [1:0] kind;
        logic       sfull;
        logic       ien;
        logic       e_main;
        logic       e_lcd;
        logic       e_wdt;
        logic [2:0] e_act;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
        '{8'h80, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001},
        '{8'h81, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'b010},
        '{8'h81, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'b001},
        '{8'h01, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001},
        '{8'h80, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b100},
        '{8'h01, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'b100},
        '{8'h81, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'b001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic enter_halt();
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
    endtask

    // Waits for the resume pulse, counting settle cycles on the way.
    task automatic wait_resume(output int n, output logic [2:0] act);
        n = 0;
        act = 3'b000;
        for (int g = 0; g < 3 * SC; g++) begin
            if (cpu_stall && !halted) n++;
            if (resume_act != 3'b000) begin
                act = resume_act;
                break;
            end
            tick();
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int       n;
        logic [2:0] a;

        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 pdf", pdf, 0);
        check("R1 tof", tof, 0);
        check("R1 ctl", ctl_rdata, 8'h00);
        check("R1 halted", halted, 0);
        check("R1 stall", cpu_stall, 0);
        check("R1 resume", resume_act, 0);
        check("R1 restart", wdt_restart, 0);
        check("R1 clk en", {main_clk_en, lcd_clk_en, wdt_clk_en}, 3'b111);

        // R3 register bits
        ctl_wr = 1'b1; ctl_wdata = 8'hFF;
        tick();
        ctl_wr = 1'b0;
        check("R3 readback", ctl_rdata, 8'h81);

        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            sysclk_is_lf = v.lf; lcd_opt = v.lopt; wdt_src_ok = v.wsrc;
            stack_full = v.sfull; irq_en = {NI{v.ien}};
            port_wake_en = 8'h01; port_in = '1; irq_req = '0;
            ctl_wr = 1'b1; ctl_wdata = v.ctl;
            tick();
            ctl_wr = 1'b0;
            enter_halt();
            check("R2 halted", halted, 1);
            check("R2 pdf", pdf, 1);
            check("R2 tof", tof, 0);
            check("R6 restart pulse", wdt_restart, v.wsrc);
            tick();
            check("R6 restart single", wdt_restart, 0);
            check("R4 main en", main_clk_en, v.e_main);
            check("R5 lcd en", lcd_clk_en, v.e_lcd);
            check("R6 wdt en", wdt_clk_en, v.e_wdt);
            case (v.kind)
                2'd0: port_in[0] = 1'b0;
                2'd1: irq_req[1] = 1'b1;
                default: wdt_ovf = 1'b1;
            endcase
            tick();
            wdt_ovf = 1'b0;
            wait_resume(n, a);
            check("R11 settle length", n, SC);
            if (v.kind == 2'd0)      check("R7 pin action", a, v.e_act);
            else if (v.kind == 2'd1) check("R8 irq action", a, v.e_act);
            else                     check("R10 wdt action", a, v.e_act);
            check("R10 tof after wake", tof, (v.kind == 2'd2));
            tick();
            check("R11 resume single", resume_act, 0);
            check("R11 stall released", cpu_stall, 0);
            port_in = '1; irq_req = '0;
            repeat (4) tick();
        end

        // R9 / R7: pending request, rising pin edge and disabled pin do not wake
        sysclk_is_lf = 0; wdt_src_ok = 1; stack_full = 0; irq_en = '1;
        port_wake_en = 8'h03; port_in = 8'hFD; irq_req = 4'b0100;
        repeat (4) tick();
        enter_halt();
        port_in = 8'hF7;   // pin1 rises (enabled), pin3 falls (disabled)
        repeat (10) tick();
        check("R9 pending irq no wake", halted, 1);
        check("R7 rising/disabled no wake", halted, 1);
        irq_req = 4'b0000;
        repeat (2) tick();
        check("R9 drop keeps halt", halted, 1);
        // R10 priority: re-armed request together with watchdog overflow
        irq_req = 4'b0100; wdt_ovf = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        wait_resume(n, a);
        check("R10 priority over irq", a, 3'b100);
        check("R11 settle length again", n, SC);
        check("R12 pdf kept after wake", pdf, 1);
        tick();
        port_in = '1; irq_req = '0;
        wdt_clr = 1'b1;
        tick();
        wdt_clr = 1'b0;
        check("R12 wdt clear", pdf, 0);

        // R9 re-arm alone: pending dropped then raised wakes as interrupt
        irq_req = 4'b0001;
        tick();
        enter_halt();
        irq_req = 4'b0000;
        repeat (2) tick();
        irq_req = 4'b0001;
        tick();
        wait_resume(n, a);
        check("R9 re-armed irq wake", a, 3'b010);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule